// File: doc/BRIEF.md
# Dual-Channel Edge-Capture Interrupt Unit

This unit produces two external interrupt requests. Each channel watches two input pins, a lower pin and an upper pin. Every pin goes through a synchroniser, then through a filter that only accepts a level held for three clocks, then into its own capture latch. Each latch can be set to capture rising edges, falling edges, both or none. A channel requests an interrupt while either of its latches holds an edge and its priority field is not zero. The priority value is driven next to the request for the arbitration logic that follows.

Software sets up each channel through one byte-wide control register on a simple peripheral bus. Channel 0 is at address 0x98 and channel 1 at 0x99. When the interrupt-taking logic pulses a channel's acknowledge, both latches of that channel clear together. Edges that gathered while the request was pending therefore produce a single interrupt. An edge that qualifies in the same cycle as the acknowledge is kept.

Each pin filter is a four-state machine:

| State | Meaning | Transition |
|---|---|---|
| FLT_LOW | The filtered level is low. | Goes to FLT_TO_HIGH when the synchronised sample is 1. |
| FLT_TO_HIGH | A high level is being counted. | Returns to FLT_LOW on a 0 sample. Goes to FLT_HIGH after the third consecutive 1. |
| FLT_HIGH | The filtered level is high. | Goes to FLT_TO_LOW when the synchronised sample is 0. |
| FLT_TO_LOW | A low level is being counted. | Returns to FLT_HIGH on a 1 sample. Goes to FLT_LOW after the third consecutive 0. |

Each capture latch is a two-state machine:

| State | Transition |
|---|---|
| CAT_IDLE | Goes to CAT_HELD on a qualifying edge. |
| CAT_HELD | Returns to CAT_IDLE on acknowledge, unless a qualifying edge arrives in that same cycle. |

Top module: `xint_unit`

## Requirements
- R1: After reset, both requests are 0, both priority outputs are 0, and both control registers read 0x00.
- R2: The channel 0 control register is at address 0x98 and the channel 1 register is at 0x99. A write stores bits 5:0. A read returns bits 5:0 with bits 7:6 as zero. A read of any other address returns 0x00.
- R3: Bits 3:2 set the edge mode of the lower pin and bits 5:4 set the edge mode of the upper pin. The encoding is 00 none, 10 rising, 01 falling and 11 both. A transition that the mode does not select sets no latch.
- R4: Bits 1:0 are the channel priority and are driven on that channel's irq_pri field. A value of 00 holds the request low even while a latch is set.
- R5: A pin level held for three clock cycles counts as a transition. A level held for only two cycles is ignored.
- R6: One acknowledge clears both latches of its channel. Edges captured on both pins before the acknowledge give one request, which drops after that single acknowledge.
- R7: If a qualifying edge arrives in the same cycle as the acknowledge, its latch stays set and the request remains.
- R8: The channels are independent. An acknowledge to one channel, or a write to one channel's register, leaves the other channel's request and register unchanged.
- R9: When a pin changes just before a rising clock edge, the request is still low after the fifth rising edge and high after the sixth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low reset, clears registers, filters and latches |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| ext_lo | input | 2 | Lower interrupt pin of each channel |
| ext_hi | input | 2 | Upper interrupt pin of each channel |
| irq_ack | input | 2 | Interrupt-taken pulse, one bit per channel |
| irq_req | output | 2 | Interrupt request, one bit per channel |
| irq_pri | output | 4 | Two-bit priority per channel, channel 0 in bits 1:0 |

## Verification
The hardest case is an edge that qualifies in exactly the cycle in which the acknowledge is sampled. The edge leaves the filter after a fixed pipeline of synchroniser and counter stages. The bench changes the pin on a falling clock edge and counts five rising edges. It then raises the acknowledge for the single cycle that ends at the sixth rising edge, the edge on which the latch would set. The merging of two edges into one request is reached by capturing edges on both pins of one channel, at different times, before giving any acknowledge.

// File: rtl/xint_pkg.sv
package xint_pkg;

    typedef enum logic [1:0] {
        FLT_LOW,
        FLT_TO_HIGH,
        FLT_HIGH,
        FLT_TO_LOW
    } flt_state_t;

    typedef enum logic {
        CAT_IDLE,
        CAT_HELD
    } cat_state_t;

    // bit 1 selects rising edges, bit 0 selects falling edges
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_mode_t;

    localparam int CFG_BITS = 6;

endpackage

// File: rtl/xint_pin_filter.sv
module xint_pin_filter
    import xint_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CLKS   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level
);
    localparam int CW = $clog2(HOLD_CLKS + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CLKS - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   smp;
    flt_state_t             state_q, state_d;
    logic [CW-1:0]          cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
    end

    assign smp = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_LOW;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            FLT_LOW: begin
                if (smp) begin
                    state_d = FLT_TO_HIGH;
                    cnt_d   = CW'(1);
                end
            end
            FLT_TO_HIGH: begin
                if (!smp)             state_d = FLT_LOW;
                else if (cnt_q == LAST) state_d = FLT_HIGH;
                else                  cnt_d   = cnt_q + CW'(1);
            end
            FLT_HIGH: begin
                if (!smp) begin
                    state_d = FLT_TO_LOW;
                    cnt_d   = CW'(1);
                end
            end
            FLT_TO_LOW: begin
                if (smp)              state_d = FLT_HIGH;
                else if (cnt_q == LAST) state_d = FLT_LOW;
                else                  cnt_d   = cnt_q + CW'(1);
            end
            default: state_d = FLT_LOW;
        endcase
    end

    always_comb begin
        level = (state_q == FLT_HIGH) || (state_q == FLT_TO_LOW);
    end

endmodule

// File: rtl/xint_catcher.sv
module xint_catcher
    import xint_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       level,
    input  edge_mode_t mode,
    input  logic       clr,
    output logic       edge_hit,
    output logic       caught
);
    logic       prev_q;
    cat_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    assign edge_hit = (mode.rise &  level & ~prev_q) |
                      (mode.fall & ~level &  prev_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CAT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAT_IDLE: if (edge_hit)         state_d = CAT_HELD;
            CAT_HELD: if (clr && !edge_hit) state_d = CAT_IDLE;
            default:                        state_d = CAT_IDLE;
        endcase
    end

    always_comb begin
        caught = (state_q == CAT_HELD);
    end

endmodule

// File: rtl/xint_ctrl_regs.sv
module xint_ctrl_regs
    import xint_pkg::*;
#(
    parameter int              NCH       = 2,
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h98
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_wr,
    input  logic [7:0]              bus_wdata,
    output logic [7:0]              bus_rdata,
    output logic [NCH*CFG_BITS-1:0] cfg_flat
);
    logic [CFG_BITS-1:0] cfg_q [NCH];
    wire unused_top_bits = ^bus_wdata[7:CFG_BITS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) cfg_q[c] <= '0;
        end else if (bus_wr) begin
            for (int c = 0; c < NCH; c++)
                if (bus_addr == BASE_ADDR + ADDR_W'(c))
                    cfg_q[c] <= bus_wdata[CFG_BITS-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NCH; c++)
            if (bus_addr == BASE_ADDR + ADDR_W'(c))
                bus_rdata = {{(8-CFG_BITS){1'b0}}, cfg_q[c]};
    end

    for (genvar c = 0; c < NCH; c++) begin : g_flat
        assign cfg_flat[c*CFG_BITS +: CFG_BITS] = cfg_q[c];
    end

endmodule

// File: rtl/xint_unit.sv
module xint_unit
    import xint_pkg::*;
#(
    parameter int                NCH         = 2,
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 8'h98,
    parameter int                SYNC_STAGES = 2,
    parameter int                HOLD_CLKS   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [NCH-1:0]    ext_lo,
    input  logic [NCH-1:0]    ext_hi,
    input  logic [NCH-1:0]    irq_ack,
    output logic [NCH-1:0]    irq_req,
    output logic [2*NCH-1:0]  irq_pri
);
    localparam int NPIN = 2 * NCH;

    logic [NCH*CFG_BITS-1:0] cfg;
    logic [NPIN-1:0]         level;
    logic [NPIN-1:0]         edge_hit;
    logic [NPIN-1:0]         caught;

    xint_ctrl_regs #(
        .NCH(NCH), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_flat(cfg)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        for (genvar p = 0; p < 2; p++) begin : g_pin
            localparam int IDX = 2*c + p;
            localparam int MSB = c*CFG_BITS + 2 + 2*p;
            logic       pin_w;
            edge_mode_t mode_w;

            assign pin_w  = (p == 1) ? ext_hi[c] : ext_lo[c];
            assign mode_w = edge_mode_t'(cfg[MSB +: 2]);

            xint_pin_filter #(
                .SYNC_STAGES(SYNC_STAGES), .HOLD_CLKS(HOLD_CLKS)
            ) u_flt (
                .clk(clk), .rst_n(rst_n), .pin(pin_w), .level(level[IDX])
            );

            xint_catcher u_cat (
                .clk(clk), .rst_n(rst_n), .level(level[IDX]), .mode(mode_w),
                .clr(irq_ack[c]), .edge_hit(edge_hit[IDX]), .caught(caught[IDX])
            );
        end
    end

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            irq_pri[2*c +: 2] = cfg[c*CFG_BITS +: 2];
            irq_req[c]        = (caught[2*c] | caught[2*c+1]) &&
                                (cfg[c*CFG_BITS +: 2] != 2'b00);
        end
    end

endmodule

module xint_unit_chk #(
    parameter int NCH = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NCH-1:0]   irq_ack,
    input logic [NCH-1:0]   irq_req,
    input logic [2*NCH-1:0] irq_pri,
    input logic [2*NCH-1:0] caught,
    input logic [2*NCH-1:0] edge_hit
);
    for (genvar c = 0; c < NCH; c++) begin : g_chan_chk
        // R4
        req_needs_pri_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_req[c] |-> (irq_pri[2*c +: 2] != 2'b00));
        // R6
        ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_ack[c] && !edge_hit[2*c] && !edge_hit[2*c+1]) |=> !irq_req[c]);
        // R7
        ack_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_ack[c] && edge_hit[2*c]) |=> caught[2*c]);
        // R7
        ack_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_ack[c] && edge_hit[2*c+1]) |=> caught[2*c+1]);
    end

    for (genvar i = 0; i < 2*NCH; i++) begin : g_pin_chk
        // R3
        edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            edge_hit[i] |=> caught[i]);
        // R8
        latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!edge_hit[i] && !irq_ack[i/2]) |=> $stable(caught[i]));
    end

endmodule

bind xint_unit xint_unit_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_ack(irq_ack), .irq_req(irq_req),
    .irq_pri(irq_pri), .caught(caught), .edge_hit(edge_hit)
);

// File: tb/sim_xint_unit.sv
`timescale 1ns/1ps
module sim_xint_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [1:0] ext_lo = '0;
    logic [1:0] ext_hi = '0;
    logic [1:0] irq_ack = '0;
    wire  [7:0] bus_rdata;
    wire  [1:0] irq_req;
    wire  [3:0] irq_pri;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    xint_unit u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_lo(ext_lo),
        .ext_hi(ext_hi), .irq_ack(irq_ack), .irq_req(irq_req), .irq_pri(irq_pri)
    );

    // {cfg[7:0], upper pin, rising transition, expected request}
    localparam logic [10:0] VEC [12] = '{
        {8'h09, 1'b0, 1'b1, 1'b1},
        {8'h09, 1'b0, 1'b0, 1'b0},
        {8'h05, 1'b0, 1'b0, 1'b1},
        {8'h05, 1'b0, 1'b1, 1'b0},
        {8'h0D, 1'b0, 1'b1, 1'b1},
        {8'h0D, 1'b0, 1'b0, 1'b1},
        {8'h22, 1'b1, 1'b1, 1'b1},
        {8'h22, 1'b1, 1'b0, 1'b0},
        {8'h13, 1'b1, 1'b0, 1'b1},
        {8'h08, 1'b0, 1'b1, 1'b0},
        {8'h01, 1'b0, 1'b1, 1'b0},
        {8'h23, 1'b0, 1'b1, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, 32'(bus_rdata), 32'(exp));
    endtask

    task automatic set_pin(input int c, input bit hi, input logic v);
        @(negedge clk);
        if (hi) ext_hi[c] = v; else ext_lo[c] = v;
    endtask

    task automatic ack(input int c);
        @(negedge clk);
        irq_ack[c] = 1'b1;
        @(negedge clk);
        irq_ack[c] = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        chk("R1 req after reset", 32'(irq_req), 0);
        chk("R1 pri after reset", 32'(irq_pri), 0);
        rd_chk("R1 reg0 after reset", 8'h98, 8'h00);
        rd_chk("R1 reg1 after reset", 8'h99, 8'h00);

        for (int k = 0; k < 12; k++) begin
            logic [7:0] cfg;
            bit hi, rise;
            logic ex;
            cfg = VEC[k][10:3]; hi = VEC[k][2]; rise = VEC[k][1]; ex = VEC[k][0];
            wr(8'h98, cfg);
            set_pin(0, hi, !rise);
            idle(8);
            ack(0);
            idle(2);
            chk("R6 clear before vector", 32'(irq_req[0]), 0);
            set_pin(0, hi, rise);
            idle(8);
            chk("R3 vector request", 32'(irq_req[0]), 32'(ex));
            chk("R4 vector priority", 32'(irq_pri[1:0]), 32'(cfg[1:0]));
            set_pin(0, hi, 1'b0);
            idle(8);
            ack(0);
            idle(2);
        end

        // R4: latch set with priority 00, request appears once priority is set
        wr(8'h98, 8'h08);
        set_pin(0, 0, 1'b1);
        idle(8);
        chk("R4 no request at pri 00", 32'(irq_req[0]), 0);
        wr(8'h98, 8'h0B);
        idle(1);
        chk("R4 request after pri set", 32'(irq_req[0]), 1);
        set_pin(0, 0, 1'b0);
        idle(8);
        ack(0);
        idle(2);

        // R9: latency of six rising edges
        wr(8'h98, 8'h09);
        set_pin(0, 0, 1'b1);
        repeat (5) @(posedge clk);
        #1 chk("R9 low after 5 edges", 32'(irq_req[0]), 0);
        @(posedge clk);
        #1 chk("R9 high after 6 edges", 32'(irq_req[0]), 1);
        set_pin(0, 0, 1'b0);
        idle(8);
        ack(0);
        idle(2);

        // R5: two-cycle pulse ignored, three-cycle pulse taken
        @(negedge clk); ext_lo[0] = 1'b1;
        idle(2);        ext_lo[0] = 1'b0;
        idle(10);
        chk("R5 two-cycle pulse ignored", 32'(irq_req[0]), 0);
        @(negedge clk); ext_lo[0] = 1'b1;
        idle(3);        ext_lo[0] = 1'b0;
        idle(10);
        chk("R5 three-cycle pulse taken", 32'(irq_req[0]), 1);
        ack(0);
        idle(2);

        // R6: two edges on one channel merge into one request
        wr(8'h99, 8'h2B);
        set_pin(1, 0, 1'b1);
        idle(8);
        set_pin(1, 1, 1'b1);
        idle(8);
        chk("R6 merged request up", 32'(irq_req[1]), 1);
        ack(1);
        idle(1);
        chk("R6 one ack drops request", 32'(irq_req[1]), 0);
        idle(6);
        chk("R6 request stays low", 32'(irq_req[1]), 0);
        set_pin(1, 0, 1'b0);
        set_pin(1, 1, 1'b0);
        idle(8);

        // R8: channel independence
        set_pin(0, 0, 1'b1);
        set_pin(1, 1, 1'b1);
        idle(8);
        chk("R8 both requests up", 32'(irq_req), 3);
        ack(0);
        idle(1);
        chk("R8 ack0 leaves ch1", 32'(irq_req), 2);
        wr(8'h98, 8'h01);
        rd_chk("R8 ch1 reg untouched", 8'h99, 8'h2B);
        chk("R8 ch1 pri untouched", 32'(irq_pri[3:2]), 3);
        ack(1);
        idle(1);
        chk("R8 ack1 drops ch1", 32'(irq_req[1]), 0);
        set_pin(0, 0, 1'b0);
        set_pin(1, 1, 1'b0);
        idle(8);
        ack(0);
        ack(1);

        // R7: edge qualifying in the acknowledge cycle is kept
        wr(8'h98, 8'h0D);
        set_pin(0, 0, 1'b1);
        idle(8);
        chk("R7 latch set first", 32'(irq_req[0]), 1);
        set_pin(0, 0, 1'b0);
        repeat (5) @(posedge clk);
        @(negedge clk); irq_ack[0] = 1'b1;
        @(negedge clk); irq_ack[0] = 1'b0;
        chk("R7 coincident edge kept", 32'(irq_req[0]), 1);
        idle(4);
        ack(0);
        idle(1);
        chk("R6 plain ack clears", 32'(irq_req[0]), 0);

        // R2: register map and readback
        wr(8'h98, 8'hFF);
        rd_chk("R2 reg0 upper bits zero", 8'h98, 8'h3F);
        wr(8'h99, 8'hC6);
        rd_chk("R2 reg1 readback", 8'h99, 8'h06);
        rd_chk("R2 below map reads zero", 8'h97, 8'h00);
        rd_chk("R2 above map reads zero", 8'h9A, 8'h00);
        wr(8'h9A, 8'h3F);
        rd_chk("R2 stray write ignored", 8'h99, 8'h06);

        // R1: reset in the middle of operation
        wr(8'h98, 8'h09);
        set_pin(0, 0, 1'b1);
        idle(8);
        chk("R1 request before reset", 32'(irq_req[0]), 1);
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        set_pin(0, 0, 1'b0);
        rst_n = 1'b1;
        idle(8);
        chk("R1 request cleared by reset", 32'(irq_req), 0);
        rd_chk("R1 reg cleared by reset", 8'h98, 8'h00);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule